// File: doc/BRIEF.md
# Partial-Tag Speculative Lookup Bank

This block is the front end of one cache bank that serves reads sent as a single narrow request flit. A read flit carries only the set index and the low eight bits of the tag. The bank reads the indexed set, compares those eight bits against every way, and streams back every way that agrees. Each returned block comes with its complete stored tag, so the requester makes the final hit decision itself. Blocks whose low tag bits match by coincidence are returned as well. Because the full tag travels back with the data, a read needs no transaction identifier.

Writes arrive over the same narrow channel as two address flits. The first carries the index and the low tag bits. The second carries the high tag bits, and the block data is sampled from a wide side input at that moment. A write performs a full tag compare against the set. Every flit has one even-parity bit, because a read has no second copy of its address to fall back on. Decoded operations wait in a small queue, so several lookups can be outstanding while an earlier response is still streaming.

Top module: `ptl_lookup_bank`

## Requirements
- R1: After reset, rsp_valid and par_err are 0, req_ready is 1, and every line is invalid, so any read returns a miss.
- R2: A flit is accepted when req_valid and req_ready are both 1. It is good when the XOR of req_flit and req_par is 0. A bad flit raises par_err in the cycle after acceptance and is otherwise discarded: no response, and no change to pending write state.
- R3: The request kind is req_flit[23:22]: 0 read, 1 write-low, 2 write-high, 3 reserved. In a read, the index is in [13:8] and the partial tag in [7:0]. Every valid way whose stored tag bits [7:0] equal the partial tag is returned.
- R4: Each returned block is a header flit (rsp_type 0) followed on consecutive cycles by four data flits (rsp_type 1). The header holds the full tag in [19:0], the way in [21:20] and the index in [27:22]. Data beat k carries block bits [128k+127:128k]. rsp_last is 1 only on the final flit of the response.
- R5: When several ways match, including coincidental matches, their blocks are returned back to back in ascending way order.
- R6: A read with no matching way returns one flit with rsp_type 2 and rsp_last 1. It holds the partial tag in [7:0], 0 in [21:20] and the index in [27:22].
- R7: A write-low flit (index [13:8], tag bits [7:0]) followed by a write-high flit (tag bits [19:8] in [11:0]) writes req_wdata under the full tag. If a valid way of the set holds that full tag, the same way is overwritten.
- R8: On a write with no full-tag hit, the block goes to the lowest-numbered invalid way. If every way is valid, it goes to a bank-wide victim counter that starts at 0 and advances by one, wrapping, on each such eviction.
- R9: A write-high flit with no pending write-low, and a reserved-kind flit, are dropped without response or state change.
- R10: Up to four decoded operations may wait while a response streams. They are served in arrival order, and req_ready is 0 while the queue is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request flit present |
| req_ready | output | 1 | Bank can accept a flit |
| req_flit | input | 24 | Request flit: kind and payload |
| req_par | input | 1 | Even-parity bit over req_flit |
| req_wdata | input | 512 | Write block, sampled with the write-high flit |
| rsp_valid | output | 1 | Response flit present |
| rsp_type | output | 2 | 0 header, 1 data, 2 miss |
| rsp_last | output | 1 | Final flit of a response |
| rsp_flit | output | 128 | Response payload |
| par_err | output | 1 | One-cycle pulse after a bad-parity flit is accepted |

## Verification
Two functions can fall in the same cycle: decoding a new flit at the input, and streaming an earlier multi-flit response. The bench provokes this by issuing reads back to back, and by injecting a corrupted flit while a block is still being returned. It then judges three things: the streamed flit sequence must match its model exactly, later reads must come out in arrival order, and the error pulse must appear without disturbing the stream in progress.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
  typedef enum logic [1:0] {
    K_READ = 2'd0,
    K_WLO  = 2'd1,
    K_WHI  = 2'd2,
    K_RSVD = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    R_HDR  = 2'd0,
    R_DATA = 2'd1,
    R_MISS = 2'd2,
    R_NONE = 2'd3
  } rsp_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOOK,
    S_HDR,
    S_DATA,
    S_MISS
  } seq_e;
endpackage

// File: rtl/ptl_flit_decode.sv
module ptl_flit_decode
  import ptl_pkg::*;
#(
  parameter int FLIT_W = 24,
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 20,
  parameter int PTAG_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [FLIT_W-1:0] flit,
  input  logic              par,
  output logic              push,
  output logic              op_wr,
  output logic [IDX_W-1:0]  op_idx,
  output logic [TAG_W-1:0]  op_tag,
  output logic              par_err
);
  localparam int HI_W = TAG_W - PTAG_W;

  kind_e             kind;
  logic              good;
  logic [IDX_W-1:0]  f_idx;
  logic [PTAG_W-1:0] f_lo;
  logic [HI_W-1:0]   f_hi;
  logic              lo_pend;
  logic [IDX_W-1:0]  lo_idx;
  logic [PTAG_W-1:0] lo_tag;

  // whole flit participates in the parity sum
  assign kind  = kind_e'(flit[FLIT_W-1 -: 2]);
  assign good  = ~(^{flit, par});
  assign f_idx = flit[PTAG_W +: IDX_W];
  assign f_lo  = flit[PTAG_W-1:0];
  assign f_hi  = flit[HI_W-1:0];

  assign push   = acc && good && ((kind == K_READ) || (kind == K_WHI && lo_pend));
  assign op_wr  = (kind == K_WHI);
  assign op_idx = op_wr ? lo_idx : f_idx;
  assign op_tag = op_wr ? {f_hi, lo_tag} : {{HI_W{1'b0}}, f_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      par_err <= 1'b0;
      lo_pend <= 1'b0;
      lo_idx  <= '0;
      lo_tag  <= '0;
    end else begin
      par_err <= acc && !good;
      if (acc && good) begin
        if (kind == K_WLO) begin
          lo_pend <= 1'b1;
          lo_idx  <= f_idx;
          lo_tag  <= f_lo;
        end else if (kind == K_WHI) begin
          lo_pend <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ptl_op_fifo.sv
module ptl_op_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_push, do_pop;

  assign full    = (cnt == (AW+1)'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/ptl_bank_store.sv
module ptl_bank_store #(
  parameter int SETS  = 64,
  parameter int WAYS  = 4,
  parameter int TAG_W = 20,
  parameter int BLK_W = 512,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [WAYS-1:0]       rd_vld,
  output logic [WAYS*TAG_W-1:0] rd_tag,
  output logic [WAYS*BLK_W-1:0] rd_data,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [WAY_W-1:0]      wr_way,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [BLK_W-1:0]      wr_data
);
  logic [WAYS-1:0] vld [SETS];

  // valid bits live in flops so reset can clear them
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) vld[s] <= '0;
      rd_vld <= '0;
    end else begin
      if (wr_en) vld[wr_idx][wr_way] <= 1'b1;
      if (rd_en) rd_vld <= vld[rd_idx];
    end
  end

  // one tag RAM and one data RAM per way, synchronous read
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tmem [SETS];
    logic [BLK_W-1:0] dmem [SETS];
    always_ff @(posedge clk) begin
      if (wr_en && wr_way == WAY_W'(w)) begin
        tmem[wr_idx] <= wr_tag;
        dmem[wr_idx] <= wr_data;
      end
      if (rd_en) begin
        rd_tag[w*TAG_W +: TAG_W]  <= tmem[rd_idx];
        rd_data[w*BLK_W +: BLK_W] <= dmem[rd_idx];
      end
    end
  end
endmodule

// File: rtl/ptl_rsp_seq.sv
module ptl_rsp_seq
  import ptl_pkg::*;
#(
  parameter int SETS    = 64,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 20,
  parameter int PTAG_W  = 8,
  parameter int BLK_W   = 512,
  parameter int DFLIT_W = 128,
  localparam int IDX_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int BEATS  = BLK_W / DFLIT_W,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  op_empty,
  input  logic                  op_wr,
  input  logic [IDX_W-1:0]      op_idx,
  input  logic [TAG_W-1:0]      op_tag,
  input  logic [BLK_W-1:0]      op_data,
  output logic                  op_pop,
  output logic                  rd_en,
  output logic [IDX_W-1:0]      rd_idx,
  input  logic [WAYS-1:0]       rd_vld,
  input  logic [WAYS*TAG_W-1:0] rd_tag,
  input  logic [WAYS*BLK_W-1:0] rd_data,
  output logic                  wr_en,
  output logic [IDX_W-1:0]      wr_idx,
  output logic [WAY_W-1:0]      wr_way,
  output logic [TAG_W-1:0]      wr_tag,
  output logic [BLK_W-1:0]      wr_data,
  output logic                  rsp_valid,
  output logic [1:0]            rsp_type,
  output logic                  rsp_last,
  output logic [DFLIT_W-1:0]    rsp_flit
);
  seq_e               state;
  logic               cur_wr;
  logic [IDX_W-1:0]   cur_idx;
  logic [TAG_W-1:0]   cur_tag;
  logic [BLK_W-1:0]   cur_data;
  logic [WAYS-1:0]    pend, pend_nx, pmatch, fmatch;
  logic [BEAT_W-1:0]  beat;
  logic [WAY_W-1:0]   rr, cur_way, victim;
  logic               evict;
  logic [TAG_W-1:0]   sel_tag;
  logic [DFLIT_W-1:0] hdr_flit, miss_flit, beat_flit;

  function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      pmatch[w] = rd_vld[w] &&
                  (rd_tag[w*TAG_W +: PTAG_W] == cur_tag[PTAG_W-1:0]);
      fmatch[w] = rd_vld[w] && (rd_tag[w*TAG_W +: TAG_W] == cur_tag);
    end
  end

  assign evict  = !(|fmatch) && (&rd_vld);
  assign victim = (|fmatch) ? lowest(fmatch) : (evict ? rr : lowest(~rd_vld));

  assign op_pop  = (state == S_IDLE) && !op_empty;
  assign rd_en   = op_pop;
  assign rd_idx  = op_idx;
  assign wr_en   = (state == S_LOOK) && cur_wr;
  assign wr_idx  = cur_idx;
  assign wr_way  = victim;
  assign wr_tag  = cur_tag;
  assign wr_data = cur_data;

  assign cur_way   = lowest(pend);
  assign sel_tag   = rd_tag[int'(cur_way)*TAG_W +: TAG_W];
  assign beat_flit = rd_data[int'(cur_way)*BLK_W + int'(beat)*DFLIT_W +: DFLIT_W];

  always_comb begin
    pend_nx = pend;
    pend_nx[cur_way] = 1'b0;
    hdr_flit = '0;
    hdr_flit[TAG_W-1:0] = sel_tag;
    hdr_flit[TAG_W +: WAY_W] = cur_way;
    hdr_flit[TAG_W+WAY_W +: IDX_W] = cur_idx;
    miss_flit = '0;
    miss_flit[PTAG_W-1:0] = cur_tag[PTAG_W-1:0];
    miss_flit[TAG_W+WAY_W +: IDX_W] = cur_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cur_wr    <= 1'b0;
      cur_idx   <= '0;
      cur_tag   <= '0;
      cur_data  <= '0;
      pend      <= '0;
      beat      <= '0;
      rr        <= '0;
      rsp_valid <= 1'b0;
      rsp_type  <= R_NONE;
      rsp_last  <= 1'b0;
      rsp_flit  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      case (state)
        S_IDLE: if (!op_empty) begin
          cur_wr   <= op_wr;
          cur_idx  <= op_idx;
          cur_tag  <= op_tag;
          cur_data <= op_data;
          state    <= S_LOOK;
        end
        S_LOOK: begin
          if (cur_wr) begin
            if (evict) rr <= (rr == WAY_W'(WAYS-1)) ? '0 : rr + 1'b1;
            state <= S_IDLE;
          end else if (|pmatch) begin
            pend  <= pmatch;
            state <= S_HDR;
          end else begin
            state <= S_MISS;
          end
        end
        S_HDR: begin
          rsp_valid <= 1'b1;
          rsp_type  <= R_HDR;
          rsp_flit  <= hdr_flit;
          beat      <= '0;
          state     <= S_DATA;
        end
        S_DATA: begin
          rsp_valid <= 1'b1;
          rsp_type  <= R_DATA;
          rsp_flit  <= beat_flit;
          if (beat == BEAT_W'(BEATS-1)) begin
            pend     <= pend_nx;
            rsp_last <= (pend_nx == '0);
            state    <= (pend_nx == '0) ? S_IDLE : S_HDR;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        S_MISS: begin
          rsp_valid <= 1'b1;
          rsp_type  <= R_MISS;
          rsp_flit  <= miss_flit;
          rsp_last  <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptl_lookup_bank.sv
module ptl_lookup_bank #(
  parameter int SETS    = 64,
  parameter int WAYS    = 4,
  parameter int TAG_W   = 20,
  parameter int PTAG_W  = 8,
  parameter int FLIT_W  = 24,
  parameter int BLK_W   = 512,
  parameter int DFLIT_W = 128,
  parameter int QDEPTH  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [FLIT_W-1:0]  req_flit,
  input  logic               req_par,
  input  logic [BLK_W-1:0]   req_wdata,
  output logic               rsp_valid,
  output logic [1:0]         rsp_type,
  output logic               rsp_last,
  output logic [DFLIT_W-1:0] rsp_flit,
  output logic               par_err
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int OP_W  = 1 + IDX_W + TAG_W + BLK_W;

  logic              acc, push, q_full, q_empty, pop;
  logic              d_wr, q_wr;
  logic [IDX_W-1:0]  d_idx, q_idx;
  logic [TAG_W-1:0]  d_tag, q_tag;
  logic [BLK_W-1:0]  q_data;
  logic [OP_W-1:0]   q_out;

  logic                  rd_en, wr_en;
  logic [IDX_W-1:0]      rd_idx, wr_idx;
  logic [WAYS-1:0]       rd_vld;
  logic [WAYS*TAG_W-1:0] rd_tag;
  logic [WAYS*BLK_W-1:0] rd_data;
  logic [WAY_W-1:0]      wr_way;
  logic [TAG_W-1:0]      wr_tag;
  logic [BLK_W-1:0]      wr_data;

  assign req_ready = !q_full;
  assign acc       = req_valid && req_ready;

  ptl_flit_decode #(
    .FLIT_W(FLIT_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .PTAG_W(PTAG_W)
  ) u_dec (
    .clk(clk), .rst(rst), .acc(acc), .flit(req_flit), .par(req_par),
    .push(push), .op_wr(d_wr), .op_idx(d_idx), .op_tag(d_tag),
    .par_err(par_err)
  );

  ptl_op_fifo #(.W(OP_W), .DEPTH(QDEPTH)) u_q (
    .clk(clk), .rst(rst), .push(push),
    .din({d_wr, d_idx, d_tag, req_wdata}),
    .pop(pop), .dout(q_out), .full(q_full), .empty(q_empty)
  );

  assign {q_wr, q_idx, q_tag, q_data} = q_out;

  ptl_bank_store #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .BLK_W(BLK_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag),
    .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_data(wr_data)
  );

  ptl_rsp_seq #(
    .SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .PTAG_W(PTAG_W),
    .BLK_W(BLK_W), .DFLIT_W(DFLIT_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .op_empty(q_empty), .op_wr(q_wr), .op_idx(q_idx), .op_tag(q_tag),
    .op_data(q_data), .op_pop(pop),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_vld(rd_vld), .rd_tag(rd_tag),
    .rd_data(rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_way(wr_way), .wr_tag(wr_tag),
    .wr_data(wr_data),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_last(rsp_last),
    .rsp_flit(rsp_flit)
  );
endmodule

// File: rtl/ptl_lookup_bank_chk.sv
module ptl_lookup_bank_chk #(
  parameter int FLIT_W  = 24,
  parameter int BLK_W   = 512,
  parameter int DFLIT_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [FLIT_W-1:0] req_flit,
  input logic              req_par,
  input logic              rsp_valid,
  input logic [1:0]        rsp_type,
  input logic              rsp_last,
  input logic              par_err
);
  localparam int BEATS = BLK_W / DFLIT_W;
  localparam int CW    = $clog2(BEATS + 1) + 1;

  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (rsp_valid && rsp_type == 2'd0) seen <= '0;
    else if (rsp_valid && rsp_type == 2'd1) seen <= seen + 1'b1;
  end

  // R2
  bad_parity_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (^{req_flit, req_par})) |=> par_err);

  // R2
  good_parity_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready && (^{req_flit, req_par})) |=> !par_err);

  // R4
  hdr_then_data_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_type == 2'd0) |=> (rsp_valid && rsp_type == 2'd1));

  // R4
  hdr_not_last_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_type == 2'd0) |-> !rsp_last);

  // R4
  beat_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_type == 2'd1) |-> (seen < CW'(BEATS)));

  // R6
  miss_single_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_type == 2'd2) |-> rsp_last);
endmodule

bind ptl_lookup_bank ptl_lookup_bank_chk #(
  .FLIT_W(FLIT_W), .BLK_W(BLK_W), .DFLIT_W(DFLIT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_flit(req_flit), .req_par(req_par), .rsp_valid(rsp_valid),
  .rsp_type(rsp_type), .rsp_last(rsp_last), .par_err(par_err)
);

// File: tb/tb_ptl_lookup_bank.sv
module tb_ptl_lookup_bank;
  localparam int SETS = 64, WAYS = 4, TAG_W = 20, BLK_W = 512, DFLIT_W = 128;
  localparam int BEATS = BLK_W / DFLIT_W;
  localparam int RW = 2 + 1 + DFLIT_W;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [23:0]        req_flit = '0;
  logic               req_par = 1'b0;
  logic [BLK_W-1:0]   req_wdata = '0;
  logic               rsp_valid, rsp_last, par_err;
  logic [1:0]         rsp_type;
  logic [DFLIT_W-1:0] rsp_flit;

  int n_chk = 0, n_fail = 0, n_err = 0;
  bit saw_busy = 0;
  bit done = 0;
  logic [RW-1:0] got_q[$];
  logic [RW-1:0] exp_q[$];

  logic             mvld [SETS][WAYS];
  logic [TAG_W-1:0] mtag [SETS][WAYS];
  logic [BLK_W-1:0] mdat [SETS][WAYS];
  int               rr_m = 0;

  always #5 clk = ~clk;

  ptl_lookup_bank dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_flit(req_flit), .req_par(req_par), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_last(rsp_last),
    .rsp_flit(rsp_flit), .par_err(par_err)
  );

  always @(negedge clk) begin
    if (!rst && rsp_valid) got_q.push_back({rsp_type, rsp_last, rsp_flit});
    if (!rst && par_err) n_err++;
  end

  task automatic chk(input bit ok, input string req, input logic [RW-1:0] act,
                     input logic [RW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [BLK_W-1:0] mk_data(input logic [31:0] seed);
    logic [BLK_W-1:0] d;
    for (int i = 0; i < BLK_W / 32; i++) d[i*32 +: 32] = seed ^ (32'h01010101 * i) ^ (i << 20);
    return d;
  endfunction

  task automatic send_flit(input logic [1:0] k, input logic [21:0] pl,
                           input bit corrupt, input logic [BLK_W-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1;
    req_flit  = {k, pl};
    req_par   = (^{k, pl}) ^ corrupt;
    req_wdata = wd;
    while (!req_ready) begin
      saw_busy = 1;
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [21:0] rd_pl(input int idx, input logic [7:0] pt);
    logic [21:0] p;
    p = '0;
    p[13:8] = 6'(idx);
    p[7:0] = pt;
    return p;
  endfunction

  task automatic expect_read(input int idx, input logic [7:0] pt);
    int nm, k;
    logic [DFLIT_W-1:0] f;
    nm = 0;
    for (int w = 0; w < WAYS; w++) if (mvld[idx][w] && mtag[idx][w][7:0] == pt) nm++;
    if (nm == 0) begin
      f = '0;
      f[7:0] = pt;
      f[27:22] = 6'(idx);
      exp_q.push_back({2'd2, 1'b1, f});
    end
    k = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (mvld[idx][w] && mtag[idx][w][7:0] == pt) begin
        k++;
        f = '0;
        f[19:0] = mtag[idx][w];
        f[21:20] = 2'(w);
        f[27:22] = 6'(idx);
        exp_q.push_back({2'd0, 1'b0, f});
        for (int b = 0; b < BEATS; b++)
          exp_q.push_back({2'd1, (k == nm && b == BEATS-1), mdat[idx][w][b*DFLIT_W +: DFLIT_W]});
      end
    end
  endtask

  task automatic do_read(input int idx, input logic [7:0] pt);
    send_flit(2'd0, rd_pl(idx, pt), 0, '0);
    expect_read(idx, pt);
  endtask

  task automatic do_write(input int idx, input logic [TAG_W-1:0] tg,
                          input logic [BLK_W-1:0] d);
    int way;
    logic [21:0] hp;
    bit allv;
    send_flit(2'd1, rd_pl(idx, tg[7:0]), 0, '0);
    hp = '0;
    hp[11:0] = tg[19:8];
    send_flit(2'd2, hp, 0, d);
    way = -1;
    for (int w = WAYS - 1; w >= 0; w--) if (mvld[idx][w] && mtag[idx][w] == tg) way = w;
    if (way < 0) for (int w = WAYS - 1; w >= 0; w--) if (!mvld[idx][w]) way = w;
    allv = (way < 0);
    if (allv) begin
      way = rr_m;
      rr_m = (rr_m + 1) % WAYS;
    end
    mvld[idx][way] = 1'b1;
    mtag[idx][way] = tg;
    mdat[idx][way] = d;
  endtask

  task automatic check_rsp(input string req);
    int guard;
    guard = 0;
    while (got_q.size() < exp_q.size() && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    repeat (12) @(negedge clk);
    chk(got_q.size() == exp_q.size(), {req, " flit count"}, RW'(got_q.size()), RW'(exp_q.size()));
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] === exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    chk(rsp_valid == 1'b0, "R1 rsp_valid", RW'(rsp_valid), '0);
    chk(par_err == 1'b0, "R1 par_err", RW'(par_err), '0);
    chk(req_ready == 1'b1, "R1 req_ready", RW'(req_ready), RW'(1));
    do_read(5, 8'h45);
    check_rsp("R1 R6 miss after reset");
  endtask

  task automatic t_single_hit();
    do_write(5, 20'h12345, mk_data(32'hA000_0001));
    do_read(5, 8'h45);
    check_rsp("R3 R4 R7 single hit");
  endtask

  task automatic t_false_pos();
    do_write(5, 20'hABC45, mk_data(32'hB000_0002));
    do_read(5, 8'h45);
    check_rsp("R5 R8 two matches ascending");
  endtask

  task automatic t_write_hit();
    do_write(5, 20'h12345, mk_data(32'hC000_0003));
    do_read(5, 8'h45);
    check_rsp("R7 full-tag hit overwrite");
  endtask

  task automatic t_evict();
    do_write(5, 20'h00011, mk_data(32'hD000_0004));
    do_write(5, 20'h00022, mk_data(32'hD000_0005));
    do_write(5, 20'h55545, mk_data(32'hD000_0006));
    do_write(5, 20'h66677, mk_data(32'hD000_0007));
    do_read(5, 8'h45);
    do_read(5, 8'h77);
    do_read(5, 8'h11);
    check_rsp("R8 round-robin eviction");
  endtask

  task automatic t_parity();
    int e0;
    logic [21:0] hp;
    e0 = n_err;
    send_flit(2'd0, rd_pl(5, 8'h45), 1, '0);
    chk(par_err == 1'b1, "R2 par_err pulse", RW'(par_err), RW'(1));
    @(negedge clk);
    chk(par_err == 1'b0, "R2 par_err one cycle", RW'(par_err), '0);
    send_flit(2'd1, rd_pl(8, 8'h99), 1, '0);
    hp = '0;
    hp[11:0] = 12'h123;
    send_flit(2'd2, hp, 0, mk_data(32'hE000_0008));
    do_read(8, 8'h99);
    check_rsp("R2 bad flit dropped");
    chk(n_err == e0 + 2, "R2 error count", RW'(n_err), RW'(e0 + 2));
  endtask

  task automatic t_dropped();
    logic [21:0] hp;
    hp = '0;
    hp[11:0] = 12'hFED;
    send_flit(2'd2, hp, 0, mk_data(32'hF000_0009));
    send_flit(2'd3, rd_pl(7, 8'h33), 0, '0);
    do_read(7, 8'h33);
    check_rsp("R9 stray write-high and reserved dropped");
  endtask

  task automatic t_outstanding();
    saw_busy = 0;
    do_write(9, 20'h0F0AA, mk_data(32'h1111_0000));
    do_write(9, 20'h1F0AA, mk_data(32'h2222_0000));
    do_read(9, 8'hAA);
    do_read(5, 8'h45);
    do_read(9, 8'hAA);
    do_read(12, 8'h01);
    do_read(9, 8'hAA);
    do_read(5, 8'h77);
    do_read(9, 8'hAA);
    check_rsp("R10 arrival order");
    chk(saw_busy, "R10 req_ready low when queue full", RW'(saw_busy), RW'(1));
  endtask

  task automatic t_err_in_stream();
    int e0;
    e0 = n_err;
    do_read(9, 8'hAA);
    repeat (3) @(negedge clk);
    send_flit(2'd0, rd_pl(9, 8'hAA), 1, '0);
    check_rsp("R2 R4 parity error during stream");
    chk(n_err == e0 + 1, "R2 error during stream", RW'(n_err), RW'(e0 + 1));
  endtask

  initial begin
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        mvld[s][w] = 1'b0;
        mtag[s][w] = '0;
        mdat[s][w] = '0;
      end
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_single_hit();
    t_false_pos();
    t_write_hit();
    t_evict();
    t_parity();
    t_dropped();
    t_outstanding();
    t_err_in_stream();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule